// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

A register-mapped general-purpose port of `NUM_PINS` pins (32 by default) that sits behind a plain single-cycle register bus: an address, a write enable, write data and combinational read data. Software sets the per-pin direction and output value, reads the pin levels after a two-flop synchronizer, and arms per-pin interrupts. The pad side is modelled as separate output-value and output-enable vectors, so the tri-state buffer stays outside the block.

Each pin's interrupt sense is chosen by two independent bits. A type bit selects edge (1) or level (0). A polarity bit selects rising/high (1) or falling/low (0). An edge event is held in a sticky pending bit until software writes a 1 to that pin's bit in the acknowledge register. A level interrupt reports the live qualified level and is never held. An enable bit gates detection and a mask bit hides a pin from the interrupt line. A raw view ignores the mask. The single interrupt output is the OR of all unmasked pending bits.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every writable register, both status views and the pin-level view read 0, `pinOe` and `pinOut` are 0 and `irqOut` is 0.
- R2: Word addresses: 0 output value, 1 direction, 2 enable, 3 mask, 4 type, 5 polarity, 6 masked status, 7 raw status, 8 acknowledge (write-only, reads 0), 9 pin level. Unmapped addresses read 0. Registers 0–5 read back what was written. The cycle after a write, `pinOut` equals register 0 and `pinOe` equals register 1, where a 1 in register 1 means output.
- R3: Address 9 returns `pinIn` delayed by two clocks: a change driven before clock edge k is visible after edge k+1 and not after edge k.
- R4: With enable=1 and type=1, polarity 1 latches a rising edge and polarity 0 latches a falling edge of the synchronized pin. The raw bit is set after the third clock edge following the pin change and stays set until it is acknowledged.
- R5: With enable=1 and type=0, the raw bit equals the synchronized level (polarity 1) or its inverse (polarity 0). It clears by itself when the level goes away.
- R6: A pin with enable=0 never shows a raw bit. A pin with mask=1 still shows its raw bit at address 7 but reads 0 at address 6.
- R7: Writing 1 to a pin's bit at address 8 clears that pin's latched edge event on the same edge. Writing 0 leaves it set. An acknowledge has no effect on a level interrupt.
- R8: If an edge is detected on the same clock edge as the acknowledge write for that pin, the pending bit stays set.
- R9: `irqOut` is 1 exactly when the masked status (address 6) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Word address |
| busWe | input | 1 | Write enable, sampled on the rising clock edge |
| busWdata | input | NUM_PINS | Write data |
| busRdata | output | NUM_PINS | Read data for `busAddr`, combinational |
| pinIn | input | NUM_PINS | Asynchronous pin levels |
| pinOut | output | NUM_PINS | Value driven on output pins |
| pinOe | output | NUM_PINS | Per-pin output enable |
| irqOut | output | 1 | Combined interrupt |

## Verification
Random trials set a random mix of type, polarity, enable and mask for every pin. Each trial then moves the pins from one random vector to another. Rising-edge, falling-edge, high-level and low-level pins are all checked in the same transition, which tells the four senses apart and tests gating by enable and by mask. Directed cases cover the acknowledge with a zero bit, a level that clears itself, the two-clock synchronizer delay, and an edge that lands on the same clock as its acknowledge. That last case separates the rule that a new event wins from the rule that a clear wins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_OUT  = 4'd0,
    REG_DIR  = 4'd1,
    REG_EN   = 4'd2,
    REG_MASK = 4'd3,
    REG_TYPE = 4'd4,
    REG_POL  = 4'd5,
    REG_STAT = 4'd6,
    REG_RAW  = 4'd7,
    REG_ACK  = 4'd8,
    REG_PIN  = 4'd9
  } regAddr_e;

  typedef struct packed {
    logic     wrOut;
    logic     wrDir;
    logic     wrEn;
    logic     wrMask;
    logic     wrType;
    logic     wrPol;
    logic     wrAck;
    logic     rdValid;
    regAddr_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctrlStrobe_t       strb
);
  always_comb begin
    strb         = '0;
    strb.rdSel   = regAddr_e'(busAddr);
    strb.rdValid = (busAddr <= ADDR_W'(REG_PIN));
    if (busWe) begin
      case (busAddr)
        REG_OUT:  strb.wrOut  = 1'b1;
        REG_DIR:  strb.wrDir  = 1'b1;
        REG_EN:   strb.wrEn   = 1'b1;
        REG_MASK: strb.wrMask = 1'b1;
        REG_TYPE: strb.wrType = 1'b1;
        REG_POL:  strb.wrPol  = 1'b1;
        REG_ACK:  strb.wrAck  = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] rdata,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut,
  output logic [NUM_PINS-1:0] rawStatus,
  output logic [NUM_PINS-1:0] edgePend,
  output logic [NUM_PINS-1:0] enBits,
  output logic [NUM_PINS-1:0] maskBits,
  output logic [NUM_PINS-1:0] pinLevel
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] outQ, dirQ, enQ, maskQ, typeQ, polQ;
  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] prevLevel, pendQ;
  logic [NUM_PINS-1:0] rise, fall, edgeHit, levelHit, ackBits, statusMasked;

  // synchronizer chain, length picked by parameter
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= '0;
        else       syncQ[g] <= pinIn;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[g] <= '0;
        else       syncQ[g] <= syncQ[g-1];
    end
  end

  assign pinLevel = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= '0; dirQ <= '0; enQ <= '0; maskQ <= '0;
      typeQ <= '0; polQ <= '0; prevLevel <= '0; pendQ <= '0;
    end else begin
      if (strb.wrOut)  outQ  <= wdata;
      if (strb.wrDir)  dirQ  <= wdata;
      if (strb.wrEn)   enQ   <= wdata;
      if (strb.wrMask) maskQ <= wdata;
      if (strb.wrType) typeQ <= wdata;
      if (strb.wrPol)  polQ  <= wdata;
      prevLevel <= pinLevel;
      // a fresh edge overrides a simultaneous acknowledge
      pendQ <= (pendQ & ~ackBits) | edgeHit;
    end
  end

  always_comb begin
    rise      = pinLevel & ~prevLevel;
    fall      = ~pinLevel & prevLevel;
    edgeHit   = enQ & typeQ & ((polQ & rise) | (~polQ & fall));
    levelHit  = enQ & ~typeQ & ((polQ & pinLevel) | (~polQ & ~pinLevel));
    ackBits   = strb.wrAck ? wdata : '0;
    rawStatus = (pendQ & enQ & typeQ) | levelHit;
    statusMasked = rawStatus & ~maskQ;
  end

  assign irqOut   = |statusMasked;
  assign pinOut   = outQ;
  assign pinOe    = dirQ;
  assign edgePend = pendQ;
  assign enBits   = enQ;
  assign maskBits = maskQ;

  always_comb begin
    rdata = '0;
    if (strb.rdValid) begin
      case (strb.rdSel)
        REG_OUT:  rdata = outQ;
        REG_DIR:  rdata = dirQ;
        REG_EN:   rdata = enQ;
        REG_MASK: rdata = maskQ;
        REG_TYPE: rdata = typeQ;
        REG_POL:  rdata = polQ;
        REG_STAT: rdata = statusMasked;
        REG_RAW:  rdata = rawStatus;
        REG_PIN:  rdata = pinLevel;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);
  ctrlStrobe_t         strb;
  logic [NUM_PINS-1:0] rawStatus, edgePend, enBits, maskBits, pinLevel;

  gpio_irq_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb)
  );

  gpio_irq_dp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wdata     (busWdata),
    .pinIn     (pinIn),
    .rdata     (busRdata),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .irqOut    (irqOut),
    .rawStatus (rawStatus),
    .edgePend  (edgePend),
    .enBits    (enBits),
    .maskBits  (maskBits),
    .pinLevel  (pinLevel)
  );
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWe,
  input logic [NUM_PINS-1:0] busWdata,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe,
  input logic                irqOut,
  input logic [NUM_PINS-1:0] rawStatus,
  input logic [NUM_PINS-1:0] edgePend,
  input logic [NUM_PINS-1:0] enBits,
  input logic [NUM_PINS-1:0] maskBits
);
  logic [NUM_PINS-1:0] ackSeen;
  assign ackSeen = (busWe && busAddr == ADDR_W'(REG_ACK)) ? busWdata : '0;

  assert_dir_drives_oe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(REG_DIR)) |=> (pinOe == $past(busWdata)));

  assert_out_drives_pin_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(REG_OUT)) |=> (pinOut == $past(busWdata)));

  assert_disabled_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((rawStatus & ~enBits) == '0));

  assert_irq_needs_unmasked_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((rawStatus & ~maskBits) != '0));

  assert_pending_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(edgePend) & ~$past(ackSeen)) & ~edgePend) == '0));
endmodule

bind gpio_irq_port gpio_irq_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWe     (busWe),
  .busWdata  (busWdata),
  .pinOut    (pinOut),
  .pinOe     (pinOe),
  .irqOut    (irqOut),
  .rawStatus (rawStatus),
  .edgePend  (edgePend),
  .enBits    (enBits),
  .maskBits  (maskBits)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   busAddr = '0;
  logic         busWe = 1'b0;
  logic [N-1:0] busWdata = '0;
  logic [N-1:0] busRdata;
  logic [N-1:0] pinDrv = '0;
  logic [N-1:0] pinOut, pinOe;
  logic         irqOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinDrv),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [N-1:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [N-1:0] v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [N-1:0] expRaw(logic [N-1:0] en, logic [N-1:0] typ,
                                          logic [N-1:0] pol, logic [N-1:0] a,
                                          logic [N-1:0] b);
    logic [N-1:0] edges, levels;
    edges  = typ & ((pol & b & ~a) | (~pol & a & ~b));
    levels = ~typ & ((pol & b) | (~pol & ~b));
    return en & (edges | levels);
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), v);
      check($sformatf("R1 reset read addr %0d", a), v, '0);
    end
    check("R1 pinOe", pinOe, '0);
    check("R1 pinOut", pinOut, '0);
    check("R1 irqOut", N'(irqOut), '0);

    // R2 output path and readback
    wr(4'd0, 32'hA5A5_0F0F);
    wr(4'd1, 32'hFFFF_0000);
    check("R2 pinOut", pinOut, 32'hA5A5_0F0F);
    check("R2 pinOe", pinOe, 32'hFFFF_0000);
    rd(4'd0, v); check("R2 readback out", v, 32'hA5A5_0F0F);
    rd(4'd1, v); check("R2 readback dir", v, 32'hFFFF_0000);
    wr(4'd2, 32'h1357_9BDF);
    rd(4'd2, v); check("R2 readback enable", v, 32'h1357_9BDF);
    wr(4'd2, '0);
    rd(4'd8, v); check("R2 ack reads zero", v, '0);
    rd(4'd13, v); check("R2 unmapped reads zero", v, '0);

    // R3 synchronizer delay
    busAddr = 4'd9;
    @(negedge clk);
    pinDrv = 32'h1234_5678;
    @(negedge clk); #1;
    check("R3 level not yet visible", busRdata, '0);
    @(negedge clk); #1;
    check("R3 level visible after two edges", busRdata, 32'h1234_5678);
    pinDrv = '0;
    waitCyc(4);

    // R4 / R7 rising edge latch, ack with zero, ack with one
    wr(4'd4, 32'h1); wr(4'd5, 32'h1); wr(4'd2, 32'h1); wr(4'd8, '1);
    pinDrv[0] = 1'b1;
    waitCyc(2);
    rd(4'd7, v); check("R4 not before third edge", v, '0);
    waitCyc(1);
    rd(4'd7, v); check("R4 rising latched", v, 32'h1);
    pinDrv[0] = 1'b0;
    waitCyc(4);
    rd(4'd7, v); check("R4 stays after pin drops", v, 32'h1);
    check("R9 irq on pending", N'(irqOut), N'(1));
    wr(4'd8, 32'hFFFF_FFFE);
    rd(4'd7, v); check("R7 ack zero bit keeps", v, 32'h1);
    wr(4'd8, 32'h1);
    rd(4'd7, v); check("R7 ack one clears", v, '0);
    check("R9 irq drops", N'(irqOut), '0);

    // R8 edge on the same clock as its ack
    pinDrv[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busAddr = 4'd8; busWe = 1'b1; busWdata = 32'h1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
    rd(4'd7, v); check("R8 new edge wins over ack", v, 32'h1);
    wr(4'd8, 32'h1);
    rd(4'd7, v); check("R8 later ack clears", v, '0);

    // R5 level interrupt follows and clears by itself; R7 ack no effect
    wr(4'd4, '0); wr(4'd5, 32'h2); wr(4'd2, 32'h2);
    pinDrv[1] = 1'b1;
    waitCyc(3);
    rd(4'd7, v); check("R5 high level shown", v, 32'h2);
    wr(4'd8, 32'h2);
    rd(4'd7, v); check("R7 ack ignores level", v, 32'h2);
    pinDrv[1] = 1'b0;
    waitCyc(3);
    rd(4'd7, v); check("R5 level clears by itself", v, '0);

    // random trials: R4 R5 R6 R9 with mixed senses
    for (int t = 0; t < 60; t++) begin
      logic [N-1:0] en, msk, typ, pol, a, b, raw;
      en = $urandom; msk = $urandom; typ = $urandom; pol = $urandom;
      a = $urandom; b = $urandom;
      if (t % 8 == 0) b = ~a;
      pinDrv = a;
      waitCyc(4);
      wr(4'd2, en); wr(4'd3, msk); wr(4'd4, typ); wr(4'd5, pol);
      wr(4'd8, '1);
      pinDrv = b;
      waitCyc(4);
      raw = expRaw(en, typ, pol, a, b);
      rd(4'd7, v); check($sformatf("R4 R5 R6 raw trial %0d", t), v, raw);
      rd(4'd6, v); check($sformatf("R6 masked status trial %0d", t), v, raw & ~msk);
      check($sformatf("R9 irq trial %0d", t), N'(irqOut), N'((raw & ~msk) != '0));
      rd(4'd9, v); check($sformatf("R3 pins trial %0d", t), v, b);
      wr(4'd8, '1);
      rd(4'd7, v); check($sformatf("R7 ack leaves levels trial %0d", t), v,
                         raw & ~typ);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule